// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a 32-pin general purpose port from a simple register bus. Each pin has a 2-bit function code. The code makes the pin either a plain software I/O or routes it to one of three peripheral options. In plain mode, software sets the pin direction and drives an output latch. It can change the latch through a data word or through set, clear and toggle strobe words that act only on bits written as 1. The pull-up enable of each pin is the inverse of a pull-up disable bit.

Control registers accept writes only while a protection-enable input is high. These registers are direction, pull-up disable, the two function-select words and the mode word. Data writes and strobe writes are always accepted. A mode value of 11 swaps peripheral option 1 on the lower sixteen pins for an alternate set of output signals.

Pin levels pass through a two-flop synchronizer. The synchronized levels are returned on data reads and are also fed to a set of peripheral inputs. A peripheral input that no pin selects sits at a per-input default value set by a parameter.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin n takes its 2-bit function code from word MXL (n<16) or MXH (n>=16), at bits [2(n mod 16)+1 : 2(n mod 16)]. The codes are 00 = plain I/O, 01 = option 1, 10 = option 2 and 11 = option 3. All codes reset to 00.
- R2: With code 00, pin_oe_o equals the direction bit (1 = output) and pin_do_o equals the output latch bit. With codes 01, 10 or 11, both come from that option's p1/p2/p3 _do_i and _oe_i bits.
- R3: The mode word holds a 2-bit field in bits [1:0]. When it is 11, option 1 on pins 0..15 takes alt_do_i and alt_oe_i instead of p1. Any other value keeps p1.
- R4: A write of 1 to a bit of SET, CLR or TGL sets, clears or inverts that latch bit. A write of 0 leaves the bit unchanged. A write to DAT loads the latch.
- R5: Writes to DIR, PUD, MXL, MXH and MODE are ignored while prot_en_i is 0. DAT, SET, CLR and TGL writes are accepted regardless of prot_en_i.
- R6: With wide_i=1, an access is 32 bits at the even word address. With wide_i=0, it is 16 bits: addr_i[0]=0 selects bits [15:0] and addr_i[0]=1 selects bits [31:16]. A narrow access uses wdata_i[15:0] and returns the half in rdata_o[15:0] with zero above.
- R7: Word addresses are DIR 0x00, PUD 0x02, MXL 0x04, MXH 0x06, MODE 0x08, DAT 0x10, SET 0x12, CLR 0x14 and TGL 0x16. Control words read back their stored value. DAT reads return pin_i through two flops, so a change shows after the second rising edge. SET, CLR, TGL and unmapped addresses read 0.
- R8: Peripheral input k follows the synchronized level of a pin p whose code is 10 and whose p mod NIN equals k. The lowest such pin wins. With no such pin, input k equals bit k of IN_DFLT.
- R9: pin_pu_o is the inverse of PUD. DIR, PUD, MODE and the output latch reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prot_en_i | input | 1 | Allows writes to control words when 1 |
| we_i | input | 1 | Write strobe |
| wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| pin_i | input | 32 | Pad input levels |
| pin_do_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables |
| pin_pu_o | output | 32 | Pad pull-up enables |
| p1_do_i | input | 32 | Option 1 output values |
| p1_oe_i | input | 32 | Option 1 output enables |
| p2_do_i | input | 32 | Option 2 output values |
| p2_oe_i | input | 32 | Option 2 output enables |
| p3_do_i | input | 32 | Option 3 output values |
| p3_oe_i | input | 32 | Option 3 output enables |
| alt_do_i | input | 16 | Alternate option 1 values, pins 0..15 |
| alt_oe_i | input | 16 | Alternate option 1 enables, pins 0..15 |
| per_in_o | output | NIN | Peripheral inputs |

## Verification
The strobe-write assertions cover full-width accesses only, so they assume the strobe address is hit with wide_i=1. The bench issues every 32-bit access at an even address to stay inside that assumption. The synchronizer assertion assumes pin_i is sampled only at clock edges. The bench changes pin_i and all bus inputs on the falling edge, so each edge sees one stable value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NPINS = 32;
  localparam int unsigned NALT  = NPINS / 2;
  localparam int unsigned AW    = 5;

  localparam logic [AW-1:0] A_DIR  = 5'h00;
  localparam logic [AW-1:0] A_PUD  = 5'h02;
  localparam logic [AW-1:0] A_MXL  = 5'h04;
  localparam logic [AW-1:0] A_MXH  = 5'h06;
  localparam logic [AW-1:0] A_MODE = 5'h08;
  localparam logic [AW-1:0] A_DAT  = 5'h10;
  localparam logic [AW-1:0] A_SET  = 5'h12;
  localparam logic [AW-1:0] A_CLR  = 5'h14;
  localparam logic [AW-1:0] A_TGL  = 5'h16;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_OPT1 = 2'b01,
    FN_OPT2 = 2'b10,
    FN_OPT3 = 2'b11
  } fn_e;

  localparam logic [1:0] MODE_ALT = 2'b11;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prot_en_i,
  input  logic             we_i,
  input  logic             wide_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [NPINS-1:0] pin_sync_i,
  output logic [31:0]      rdata_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] pud_o,
  output logic [31:0]      mxl_o,
  output logic [31:0]      mxh_o,
  output logic [1:0]       mode_o,
  output logic [NPINS-1:0] out_o
);
  logic [NPINS-1:0] dir_q, pud_q, out_q;
  logic [31:0]      mxl_q, mxh_q;
  logic [1:0]       mode_q;
  logic [31:0]      wpos, wmsk, rval;
  logic [AW-1:0]    sel;

  assign sel = {addr_i[AW-1:1], 1'b0};

  // lane placement of write data
  always_comb begin
    if (wide_i) begin
      wpos = wdata_i;
      wmsk = '1;
    end else if (addr_i[0]) begin
      wpos = {wdata_i[15:0], 16'h0000};
      wmsk = 32'hFFFF_0000;
    end else begin
      wpos = {16'h0000, wdata_i[15:0]};
      wmsk = 32'h0000_FFFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      pud_q  <= '0;
      mxl_q  <= '0;
      mxh_q  <= '0;
      mode_q <= '0;
      out_q  <= '0;
    end else if (we_i) begin
      unique case (sel)
        A_DIR:  if (prot_en_i) dir_q <= (dir_q & ~wmsk) | wpos;
        A_PUD:  if (prot_en_i) pud_q <= (pud_q & ~wmsk) | wpos;
        A_MXL:  if (prot_en_i) mxl_q <= (mxl_q & ~wmsk) | wpos;
        A_MXH:  if (prot_en_i) mxh_q <= (mxh_q & ~wmsk) | wpos;
        A_MODE: if (prot_en_i) mode_q <= (mode_q & ~wmsk[1:0]) | wpos[1:0];
        A_DAT:  out_q <= (out_q & ~wmsk) | wpos;
        A_SET:  out_q <= out_q | wpos;
        A_CLR:  out_q <= out_q & ~wpos;
        A_TGL:  out_q <= out_q ^ wpos;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      A_DIR:   rval = dir_q;
      A_PUD:   rval = pud_q;
      A_MXL:   rval = mxl_q;
      A_MXH:   rval = mxh_q;
      A_MODE:  rval = {30'h0, mode_q};
      A_DAT:   rval = pin_sync_i;
      default: rval = '0;
    endcase
    if (wide_i)         rdata_o = rval;
    else if (addr_i[0]) rdata_o = {16'h0000, rval[31:16]};
    else                rdata_o = {16'h0000, rval[15:0]};
  end

  assign dir_o  = dir_q;
  assign pud_o  = pud_q;
  assign mxl_o  = mxl_q;
  assign mxh_o  = mxh_q;
  assign mode_o = mode_q;
  assign out_o  = out_q;

  // R5
  ctrl_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !prot_en_i && !addr_i[AW-1]) |=>
      ($stable(dir_q) && $stable(pud_q) && $stable(mxl_q) && $stable(mxh_q) && $stable(mode_q)));
  // R4
  set_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wide_i && addr_i == A_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));
  // R4
  clr_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wide_i && addr_i == A_CLR) |=> ((out_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic [2*NPINS-1:0] fn_i,
  input  logic               alt_i,
  input  logic [NPINS-1:0]   dir_i,
  input  logic [NPINS-1:0]   out_i,
  input  logic [NPINS-1:0]   p1_do_i,
  input  logic [NPINS-1:0]   p1_oe_i,
  input  logic [NPINS-1:0]   p2_do_i,
  input  logic [NPINS-1:0]   p2_oe_i,
  input  logic [NPINS-1:0]   p3_do_i,
  input  logic [NPINS-1:0]   p3_oe_i,
  input  logic [NALT-1:0]    alt_do_i,
  input  logic [NALT-1:0]    alt_oe_i,
  output logic [NPINS-1:0]   do_o,
  output logic [NPINS-1:0]   oe_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] fn;
    logic       o1_do, o1_oe;
    assign fn = fn_i[2*p +: 2];

    if (p < NALT) begin : g_alt
      assign o1_do = alt_i ? alt_do_i[p] : p1_do_i[p];
      assign o1_oe = alt_i ? alt_oe_i[p] : p1_oe_i[p];
    end else begin : g_std
      assign o1_do = p1_do_i[p];
      assign o1_oe = p1_oe_i[p];
    end

    always_comb begin
      unique case (fn)
        FN_OPT1: begin do_o[p] = o1_do;      oe_o[p] = o1_oe;      end
        FN_OPT2: begin do_o[p] = p2_do_i[p]; oe_o[p] = p2_oe_i[p]; end
        FN_OPT3: begin do_o[p] = p3_do_i[p]; oe_o[p] = p3_oe_i[p]; end
        default: begin do_o[p] = out_i[p];   oe_o[p] = dir_i[p];   end
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_route.sv
module gpio_in_route
  import gpio_port_pkg::*;
#(
  parameter int unsigned    NIN     = 8,
  parameter logic [NIN-1:0] IN_DFLT = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPINS-1:0]   pin_i,
  input  logic [2*NPINS-1:0] fn_i,
  output logic [NPINS-1:0]   sync_o,
  output logic [NIN-1:0]     per_in_o
);
  logic [NPINS-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;

  // descending scan: lowest matching pin is applied last
  always_comb begin
    for (int k = 0; k < int'(NIN); k++) begin
      per_in_o[k] = IN_DFLT[k];
      for (int p = int'(NPINS) - 1; p >= 0; p--) begin
        if ((p % int'(NIN)) == k && fn_i[2*p +: 2] == FN_OPT2) per_in_o[k] = s2_q[p];
      end
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R7
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (s2_q == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned    NIN     = 8,
  parameter logic [NIN-1:0] IN_DFLT = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prot_en_i,
  input  logic             we_i,
  input  logic             wide_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_do_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pin_pu_o,
  input  logic [NPINS-1:0] p1_do_i,
  input  logic [NPINS-1:0] p1_oe_i,
  input  logic [NPINS-1:0] p2_do_i,
  input  logic [NPINS-1:0] p2_oe_i,
  input  logic [NPINS-1:0] p3_do_i,
  input  logic [NPINS-1:0] p3_oe_i,
  input  logic [NALT-1:0]  alt_do_i,
  input  logic [NALT-1:0]  alt_oe_i,
  output logic [NIN-1:0]   per_in_o
);
  logic [NPINS-1:0]   dir, pud, out_lat, sync;
  logic [31:0]        mxl, mxh;
  logic [1:0]         mode;
  logic [2*NPINS-1:0] fn_all;

  assign fn_all   = {mxh, mxl};
  assign pin_pu_o = ~pud;

  gpio_regs u_regs (
    .clk_i, .rst_ni, .prot_en_i, .we_i, .wide_i, .addr_i, .wdata_i,
    .pin_sync_i(sync), .rdata_o,
    .dir_o(dir), .pud_o(pud), .mxl_o(mxl), .mxh_o(mxh), .mode_o(mode), .out_o(out_lat)
  );

  gpio_pin_mux u_mux (
    .fn_i(fn_all), .alt_i(mode == MODE_ALT), .dir_i(dir), .out_i(out_lat),
    .p1_do_i, .p1_oe_i, .p2_do_i, .p2_oe_i, .p3_do_i, .p3_oe_i,
    .alt_do_i, .alt_oe_i, .do_o(pin_do_o), .oe_o(pin_oe_o)
  );

  gpio_in_route #(.NIN(NIN), .IN_DFLT(IN_DFLT)) u_route (
    .clk_i, .rst_ni, .pin_i, .fn_i(fn_all), .sync_o(sync), .per_in_o
  );

  // R3
  alt_opt1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_ALT && mxl[1:0] == FN_OPT1) |->
      (pin_do_o[0] == alt_do_i[0] && pin_oe_o[0] == alt_oe_i[0]));
  // R2
  gpio_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mxh[31:30] == FN_GPIO) |-> (pin_oe_o[NPINS-1] == dir[NPINS-1]));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam logic [7:0] DFLT = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot = 1'b0, we = 1'b0, wide = 1'b1;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pin = '0, pdo, poe, ppu;
  logic [31:0] p1d = 32'hA5A5_0F0F, p1e = 32'hFFFF_0000;
  logic [31:0] p2d = 32'h3C3C_3C3C, p2e = 32'h0F0F_F0F0;
  logic [31:0] p3d = 32'h1234_ABCD, p3e = 32'hFFFF_FFFF;
  logic [15:0] ald = 16'h5A5A, ale = 16'h00FF;
  logic [7:0]  per;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_dir = '0, m_pud = '0, m_mxl = '0, m_mxh = '0, m_out = '0;
  logic [1:0]  m_mode = '0;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.NIN(8), .IN_DFLT(DFLT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .prot_en_i(prot), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin),
    .pin_do_o(pdo), .pin_oe_o(poe), .pin_pu_o(ppu),
    .p1_do_i(p1d), .p1_oe_i(p1e), .p2_do_i(p2d), .p2_oe_i(p2e),
    .p3_do_i(p3d), .p3_oe_i(p3e), .alt_do_i(ald), .alt_oe_i(ale), .per_in_o(per)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fn_of(input int p);
    return (p < 16) ? m_mxl[2*(p%16) +: 2] : m_mxh[2*(p%16) +: 2];
  endfunction

  function automatic logic [63:0] exp_pins();
    logic [31:0] d, e;
    for (int p = 0; p < 32; p++) begin
      unique case (fn_of(p))
        2'b01: begin
          if (p < 16 && m_mode == 2'b11) begin d[p] = ald[p]; e[p] = ale[p]; end
          else begin d[p] = p1d[p]; e[p] = p1e[p]; end
        end
        2'b10: begin d[p] = p2d[p]; e[p] = p2e[p]; end
        2'b11: begin d[p] = p3d[p]; e[p] = p3e[p]; end
        default: begin d[p] = m_out[p]; e[p] = m_dir[p]; end
      endcase
    end
    return {d, e};
  endfunction

  function automatic logic [7:0] exp_per();
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      v[k] = DFLT[k];
      for (int p = 31; p >= 0; p--) if (p % 8 == k && fn_of(p) == 2'b10) v[k] = pin[p];
    end
    return v;
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic w);
    logic [31:0] pos, msk;
    @(negedge clk);
    addr = a; wdata = d; wide = w; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    pos = w ? d : (a[0] ? {d[15:0], 16'h0} : {16'h0, d[15:0]});
    msk = w ? '1 : (a[0] ? 32'hFFFF_0000 : 32'h0000_FFFF);
    unique case ({a[4:1], 1'b0})
      5'h00: if (prot) m_dir = (m_dir & ~msk) | pos;
      5'h02: if (prot) m_pud = (m_pud & ~msk) | pos;
      5'h04: if (prot) m_mxl = (m_mxl & ~msk) | pos;
      5'h06: if (prot) m_mxh = (m_mxh & ~msk) | pos;
      5'h08: if (prot) m_mode = (m_mode & ~msk[1:0]) | pos[1:0];
      5'h10: m_out = (m_out & ~msk) | pos;
      5'h12: m_out = m_out | pos;
      5'h14: m_out = m_out & ~pos;
      5'h16: m_out = m_out ^ pos;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    addr = a; wide = w;
    #1 d = rdata;
  endtask

  task automatic chk_pins(input string req);
    logic [63:0] e;
    e = exp_pins();
    chk({req, " do"}, pdo, e[63:32]);
    chk({req, " oe"}, poe, e[31:0]);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    bus_rd(5'h00, 1'b1, r); chk("R9 dir reset", r, 0);
    bus_rd(5'h04, 1'b1, r); chk("R1 mxl reset", r, 0);
    bus_rd(5'h06, 1'b1, r); chk("R1 mxh reset", r, 0);
    bus_rd(5'h08, 1'b1, r); chk("R9 mode reset", r, 0);
    chk("R9 pu reset", ppu, 32'hFFFF_FFFF);
    chk_pins("R2 reset");
    chk("R8 defaults", {24'h0, per}, {24'h0, DFLT});
  endtask

  task automatic t_protect();
    logic [31:0] r;
    prot = 1'b0;
    bus_wr(5'h00, 32'hFFFF_FFFF, 1'b1);
    bus_wr(5'h04, 32'h5555_5555, 1'b1);
    bus_wr(5'h08, 32'h3, 1'b1);
    bus_rd(5'h00, 1'b1, r); chk("R5 dir locked", r, 0);
    bus_rd(5'h04, 1'b1, r); chk("R5 mxl locked", r, 0);
    bus_rd(5'h08, 1'b1, r); chk("R5 mode locked", r, 0);
    bus_wr(5'h10, 32'h1234_5678, 1'b1);
    chk_pins("R5 dat open");
    prot = 1'b1;
    bus_wr(5'h00, 32'hF0F0_00FF, 1'b1);
    bus_wr(5'h02, 32'h0000_FF00, 1'b1);
    bus_rd(5'h00, 1'b1, r); chk("R5 dir open", r, 32'hF0F0_00FF);
    chk("R9 pu", ppu, 32'hFFFF_00FF);
    chk_pins("R2 gpio");
  endtask

  task automatic t_strobes();
    logic [31:0] r;
    bus_wr(5'h12, 32'h8000_0001, 1'b1); chk_pins("R4 set");
    bus_wr(5'h14, 32'h1200_0008, 1'b1); chk_pins("R4 clr");
    bus_wr(5'h16, 32'hFFFF_0000, 1'b1); chk_pins("R4 tgl");
    bus_wr(5'h17, 32'h0000_00F0, 1'b0); chk_pins("R6 tgl hi half");
    bus_wr(5'h12, 32'h0000_0F00, 1'b0); chk_pins("R6 set lo half");
    bus_wr(5'h15, 32'h0000_FFFF, 1'b0); chk_pins("R6 clr hi half");
    bus_wr(5'h16, 32'h0000_0000, 1'b1); chk_pins("R4 zero tgl");
    bus_rd(5'h12, 1'b1, r); chk("R7 set reads 0", r, 0);
    bus_rd(5'h14, 1'b1, r); chk("R7 clr reads 0", r, 0);
    bus_rd(5'h16, 1'b1, r); chk("R7 tgl reads 0", r, 0);
  endtask

  task automatic t_half();
    logic [31:0] r;
    bus_wr(5'h01, 32'hFFFF_ABCD, 1'b0);
    bus_wr(5'h00, 32'h0000_1357, 1'b0);
    bus_rd(5'h00, 1'b1, r); chk("R6 dir halves", r, 32'hABCD_1357);
    bus_rd(5'h01, 1'b0, r); chk("R6 hi read", r, 32'h0000_ABCD);
    bus_rd(5'h00, 1'b0, r); chk("R6 lo read", r, 32'h0000_1357);
    chk_pins("R2 after halves");
  endtask

  task automatic t_mux();
    bus_wr(5'h04, 32'h0000_C801, 1'b1);
    bus_wr(5'h06, 32'h4000_000D, 1'b1);
    chk_pins("R1 std map");
    bus_wr(5'h08, 32'h0000_0003, 1'b1);
    chk_pins("R3 alt map");
    chk("R3 pin0 alt", {31'h0, pdo[0]}, {31'h0, ald[0]});
    bus_wr(5'h08, 32'h0000_0001, 1'b1);
    chk_pins("R3 mode 01 std");
    bus_wr(5'h04, 32'h0000_0000, 1'b1);
    bus_wr(5'h06, 32'h0000_0000, 1'b1);
    chk_pins("R2 back to gpio");
  endtask

  task automatic t_route();
    logic [31:0] r;
    bus_wr(5'h04, 32'h0080_0080, 1'b1);
    bus_wr(5'h06, 32'h0000_0200, 1'b1);
    @(negedge clk); pin = 32'h0010_0008; addr = 5'h10; wide = 1'b1;
    @(posedge clk); #1 chk("R7 sync 1 edge", rdata, 0);
    @(posedge clk); #1 chk("R7 sync 2 edges", rdata, 32'h0010_0008);
    chk("R8 route", {24'h0, per}, {24'h0, exp_per()});
    @(negedge clk); pin = 32'h0000_0800;
    repeat (3) @(posedge clk);
    #1 chk("R8 lowest pin wins", {24'h0, per}, {24'h0, exp_per()});
    bus_wr(5'h04, 32'h0080_0000, 1'b1);
    repeat (2) @(posedge clk);
    #1 chk("R8 next pin", {24'h0, per}, {24'h0, exp_per()});
    bus_rd(5'h10, 1'b1, r); chk("R7 dat read", r, pin);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_protect();
    t_strobes();
    t_half();
    t_mux();
    t_route();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule